// File: doc/BRIEF.md
# Periodic Limit Timer with Free-Running User Counter

This block is a memory-mapped counter/timer serving one processor. A counter advances on each pulse of an external tick-enable input (nominally one pulse per 500 ns). Count and limit values are stored left-justified, so one tick adds 1 at bit 9 of the register word. Bits 8..0 of every count and limit word always read as zero. The block offers a small 32-bit word register window with a single interrupt output.

The `user_mode` input selects one of two personalities. In system mode the 22 meaningful count bits are compared with a programmable limit. When a tick brings the count to the limit, the counter restarts from zero, a reached flag is set in bit 31 of the count word, and the interrupt is raised. Software clears the interrupt by reading the limit register. In user mode the same storage becomes a free-running 64-bit counter (55 meaningful bits) that software can start and stop. It is read as a high word and a low word and never interrupts. Register index is `addr[4:2]`.

The register port uses plain strobes rather than valid/ready: every access is accepted in the cycle it is presented, so there is no back-pressure. A read presented with `rd_en` returns its word with `rd_valid` one cycle later. Ticks, mode and interrupt are plain control pins.

Top module: `limit_count_timer`

## Requirements
- R1: After reset the interrupt is low, the limit word reads 0x7FFFFE00, the count word (index 1) reads 0 and the run flag (index 2, bit 0) reads 1.
- R2: Each cycle with `tick_en` high adds 0x200 to the count word (index 1); bits 8..0 of the count word always read 0.
- R3: In system mode, when a tick brings the count to the limit, the count restarts at 0, bit 31 of the count word (reached flag) becomes 1 and `irq` goes high at that clock edge; this repeats every limit period.
- R4: In system mode a read of index 0 returns the limit word with bit 31 clear and lowers `irq` at the clock edge that samples the read; an expiry on that same edge wins and leaves `irq` high.
- R5: In system mode a write to index 0 loads limit = wdata & 0x7FFFFE00, clears the count and the reached flag, and lowers `irq`.
- R6: In system mode a write to index 1 loads the limit the same way but leaves the count, the reached flag and `irq` unchanged.
- R7: A limit write whose masked value is zero stores 0x7FFFFE00 instead.
- R8: In user mode index 0 returns bits 63..32 and index 1 bits 31..0 of the 64-bit counter (bits 8..0 zero), and `irq` stays low however many ticks arrive.
- R9: In user mode a write to index 0 or index 1 clears the counter and lowers `irq`.
- R10: Index 2 reads the run flag in bit 0 (bits 31..1 zero); in user mode writing bit 0 starts (1) or stops (0) counting, while in system mode such writes are ignored and the counter keeps running.
- R11: At the first clock edge where `user_mode` differs from the mode in force, the block adopts the new mode: count 0, limit 0x7FFFFE00, reached flag 0, run flag 1, `irq` low; a bus write in that cycle is dropped.
- R12: `rd_valid` is high exactly one cycle after each `rd_en`; indexes 3 to 7 read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse that advances the counter |
| user_mode | input | 1 | 1 selects the free-running user counter, 0 the limit timer |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address; bits 4..2 select the register |
| wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rdata | output | 32 | Read data |
| irq | output | 1 | Interrupt, high from expiry until cleared |

## Verification
The hardest situation to reach from the ports is an expiry landing on the same clock edge as the interrupt-clearing limit read. In that case the set must beat the clear. The stimulus programs a two-tick limit, spends one tick, and then issues the limit read in the same cycle as the second tick. The stimulus also switches mode while the interrupt is high, and it stops and restarts the user counter between ticks so that a frozen count can be told apart from a moving one.

// File: rtl/lct_pkg.sv
package lct_pkg;
  typedef enum logic [2:0] {
    IDX_HI  = 3'd0,
    IDX_LO  = 3'd1,
    IDX_RUN = 3'd2
  } reg_idx_e;

  typedef struct packed {
    logic wr_hi;
    logic wr_lo;
    logic wr_run;
    logic rd_hi;
  } lct_cmd_t;
endpackage

// File: rtl/lct_regdec.sv
module lct_regdec
  import lct_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output lct_cmd_t          cmd,
  output logic [2:0]        idx
);
  logic unused_addr;
  assign unused_addr = ^{addr[1:0], addr[ADDR_W-1:5]};

  assign idx = addr[4:2];

  always_comb begin
    cmd        = '0;
    cmd.wr_hi  = wr_en && (idx == IDX_HI);
    cmd.wr_lo  = wr_en && (idx == IDX_LO);
    cmd.wr_run = wr_en && (idx == IDX_RUN);
    cmd.rd_hi  = rd_en && (idx == IDX_HI);
  end
endmodule

// File: rtl/lct_core.sv
module lct_core
  import lct_pkg::*;
#(
  parameter int SYS_UNITS = 22,
  parameter int USR_UNITS = 55
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 user_mode,
  input  lct_cmd_t             cmd,
  input  logic [SYS_UNITS-1:0] wlimit,
  input  logic                 wrun,
  output logic                 mode_q,
  output logic [USR_UNITS-1:0] count,
  output logic [SYS_UNITS-1:0] limit,
  output logic                 reached,
  output logic                 run,
  output logic                 irq
);
  localparam logic [SYS_UNITS-1:0] LIMIT_MAX = '1;

  logic                 mode_chg;
  logic [SYS_UNITS-1:0] sys_next;
  logic [SYS_UNITS-1:0] limit_ld;
  logic                 expire;

  assign mode_chg = (user_mode != mode_q);
  assign sys_next = count[SYS_UNITS-1:0] + 1'b1;
  assign limit_ld = (wlimit == '0) ? LIMIT_MAX : wlimit;
  assign expire   = tick_en && (sys_next == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= user_mode;
      count   <= '0;
      limit   <= LIMIT_MAX;
      reached <= 1'b0;
      run     <= 1'b1;
      irq     <= 1'b0;
    end else if (mode_chg) begin
      mode_q  <= user_mode;
      count   <= '0;
      limit   <= LIMIT_MAX;
      reached <= 1'b0;
      run     <= 1'b1;
      irq     <= 1'b0;
    end else if (!mode_q) begin
      if (cmd.wr_hi) begin
        limit   <= limit_ld;
        count   <= '0;
        reached <= 1'b0;
        irq     <= 1'b0;
      end else begin
        if (cmd.wr_lo) limit <= limit_ld;
        if (expire) begin
          count   <= '0;
          reached <= 1'b1;
          irq     <= 1'b1;
        end else begin
          if (tick_en) count <= {{(USR_UNITS-SYS_UNITS){1'b0}}, sys_next};
          if (cmd.rd_hi) irq <= 1'b0;
        end
      end
    end else begin
      if (cmd.wr_hi || cmd.wr_lo) begin
        count <= '0;
        irq   <= 1'b0;
      end else if (tick_en && run) begin
        count <= count + 1'b1;
      end
      if (cmd.wr_run) run <= wrun;
    end
  end
endmodule

// File: rtl/lct_rdmux.sv
module lct_rdmux
  import lct_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int CNT_LSB   = 9,
  parameter int SYS_UNITS = 22,
  parameter int USR_UNITS = 55
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic [2:0]           idx,
  input  logic                 mode_q,
  input  logic [USR_UNITS-1:0] count,
  input  logic [SYS_UNITS-1:0] limit,
  input  logic                 reached,
  input  logic                 run,
  output logic                 rd_valid,
  output logic [WORD_W-1:0]    rdata
);
  logic [2*WORD_W-1:0] wide;
  logic [WORD_W-1:0]   word;

  assign wide = {count, {CNT_LSB{1'b0}}};

  always_comb begin
    word = '0;
    case (idx)
      IDX_HI:  word = mode_q ? wide[2*WORD_W-1:WORD_W]
                             : {1'b0, limit, {CNT_LSB{1'b0}}};
      IDX_LO:  word = mode_q ? wide[WORD_W-1:0]
                             : {reached, count[SYS_UNITS-1:0], {CNT_LSB{1'b0}}};
      IDX_RUN: word = {{(WORD_W-1){1'b0}}, run};
      default: word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rdata    <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= word;
    end
  end
endmodule

// File: rtl/limit_count_timer.sv
module limit_count_timer
  import lct_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int CNT_LSB = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              user_mode,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic              rd_valid,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam int WORD_W    = 32;
  localparam int SYS_UNITS = WORD_W - 1 - CNT_LSB;
  localparam int USR_UNITS = 2 * WORD_W - CNT_LSB;

  lct_cmd_t             cmd;
  logic [2:0]           idx;
  logic                 mode_q;
  logic [USR_UNITS-1:0] count;
  logic [SYS_UNITS-1:0] limit;
  logic                 reached;
  logic                 run;
  logic                 unused_wbits;

  assign unused_wbits = ^{wdata[WORD_W-1], wdata[CNT_LSB-1:1]};

  lct_regdec #(.ADDR_W(ADDR_W)) dec_i (
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .cmd   (cmd),
    .idx   (idx)
  );

  lct_core #(.SYS_UNITS(SYS_UNITS), .USR_UNITS(USR_UNITS)) core_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .user_mode (user_mode),
    .cmd       (cmd),
    .wlimit    (wdata[WORD_W-2:CNT_LSB]),
    .wrun      (wdata[0]),
    .mode_q    (mode_q),
    .count     (count),
    .limit     (limit),
    .reached   (reached),
    .run       (run),
    .irq       (irq)
  );

  lct_rdmux #(
    .WORD_W(WORD_W), .CNT_LSB(CNT_LSB),
    .SYS_UNITS(SYS_UNITS), .USR_UNITS(USR_UNITS)
  ) rd_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .idx      (idx),
    .mode_q   (mode_q),
    .count    (count),
    .limit    (limit),
    .reached  (reached),
    .run      (run),
    .rd_valid (rd_valid),
    .rdata    (rdata)
  );
endmodule

// File: rtl/lct_checker.sv
module lct_checker #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              user_mode,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_valid,
  input logic [31:0]       rdata,
  input logic              irq
);
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R12
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R12
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[4:2] > 3'd2) |=> (rdata == 32'd0)); // R12
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[4:2] == 3'd1) |=> (rdata[8:0] == 9'd0)); // R2
  AST_RUN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[4:2] == 3'd2) |=> (rdata[31:1] == 31'd0)); // R10
  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick_en)); // R3
  AST_WRITE_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[4:2] == 3'd0) |=> !irq); // R5
  AST_USER_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && $past(user_mode)) |-> !irq); // R8
endmodule

bind limit_count_timer lct_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .user_mode (user_mode),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .rd_valid  (rd_valid),
  .rdata     (rdata),
  .irq       (irq)
);

// File: tb/limit_count_timer_tb_top.sv
module limit_count_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        user_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rd_valid;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  limit_count_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .user_mode(user_mode),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rd_valid(rd_valid), .rdata(rdata), .irq(irq)
  );

  // monitor: pops the scoreboard whenever the design returns a read word
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R12: unexpected rd_valid, data %h expected none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s: rdata %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic bus_rd(input logic [2:0] idx, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b1; addr = {idx, 2'b00};
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [2:0] idx, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; addr = {idx, 2'b00}; wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    chk_irq(1'b0, "R1");
    bus_rd(3'd0, 32'h7FFF_FE00, "R1");
    bus_rd(3'd1, 32'h0000_0000, "R1");
    bus_rd(3'd2, 32'h0000_0001, "R1");
    bus_rd(3'd5, 32'h0000_0000, "R12");
    // limit write masks low bits and bit 31; limit = 5 ticks
    bus_wr(3'd0, 32'h8000_0BFF);
    bus_rd(3'd0, 32'h0000_0A00, "R5");
    ticks(3);
    bus_rd(3'd1, 32'h0000_0600, "R2");
    chk_irq(1'b0, "R3");
    ticks(2);
    chk_irq(1'b1, "R3");
    bus_rd(3'd1, 32'h8000_0000, "R3");
    ticks(5);
    bus_rd(3'd1, 32'h8000_0000, "R3");
    ticks(1);
    bus_rd(3'd1, 32'h8000_0200, "R2");
    chk_irq(1'b1, "R3");
    bus_rd(3'd0, 32'h0000_0A00, "R4");
    chk_irq(1'b0, "R4");
    // index 1 write: new limit 8, count kept
    bus_wr(3'd1, 32'h0000_1000);
    bus_rd(3'd1, 32'h8000_0200, "R6");
    bus_rd(3'd0, 32'h0000_1000, "R6");
    ticks(6);
    bus_rd(3'd1, 32'h8000_0E00, "R6");
    chk_irq(1'b0, "R6");
    ticks(1);
    chk_irq(1'b1, "R6");
    bus_rd(3'd1, 32'h8000_0000, "R6");
    // zero limit maps to maximum, write clears count, flag and irq
    bus_wr(3'd0, 32'h0000_01FF);
    chk_irq(1'b0, "R5");
    bus_rd(3'd0, 32'h7FFF_FE00, "R7");
    bus_rd(3'd1, 32'h0000_0000, "R5");
    // run control ignored in system mode
    bus_wr(3'd2, 32'h0000_0000);
    bus_rd(3'd2, 32'h0000_0001, "R10");
    ticks(2);
    bus_rd(3'd1, 32'h0000_0400, "R10");
    // unmapped write changes nothing
    bus_wr(3'd5, 32'h0000_1200);
    bus_rd(3'd0, 32'h7FFF_FE00, "R12");
    bus_rd(3'd1, 32'h0000_0400, "R12");
    // expiry coincides with the clearing read: set wins
    bus_wr(3'd0, 32'h0000_0400);
    ticks(1);
    exp_q.push_back(32'h0000_0400);
    tag_q.push_back("R4");
    @(negedge clk);
    tick_en = 1'b1; rd_en = 1'b1; addr = 5'd0;
    @(negedge clk);
    tick_en = 1'b0; rd_en = 1'b0;
    chk_irq(1'b1, "R4");
    bus_rd(3'd1, 32'h8000_0000, "R4");
    // mode change with irq high
    @(negedge clk);
    user_mode = 1'b1;
    @(negedge clk);
    chk_irq(1'b0, "R11");
    bus_rd(3'd1, 32'h0000_0000, "R11");
    bus_rd(3'd0, 32'h0000_0000, "R11");
    bus_rd(3'd2, 32'h0000_0001, "R11");
    // user counter
    ticks(3);
    bus_rd(3'd1, 32'h0000_0600, "R8");
    ticks(10);
    bus_rd(3'd1, 32'h0000_1A00, "R8");
    bus_rd(3'd0, 32'h0000_0000, "R8");
    chk_irq(1'b0, "R8");
    bus_wr(3'd2, 32'h0000_0000);
    bus_rd(3'd2, 32'h0000_0000, "R10");
    ticks(4);
    bus_rd(3'd1, 32'h0000_1A00, "R10");
    bus_wr(3'd2, 32'h0000_0001);
    ticks(1);
    bus_rd(3'd1, 32'h0000_1C00, "R10");
    bus_wr(3'd1, 32'h1234_5678);
    bus_rd(3'd1, 32'h0000_0000, "R9");
    ticks(2);
    bus_rd(3'd1, 32'h0000_0400, "R9");
    bus_wr(3'd0, 32'hFFFF_FFFF);
    bus_rd(3'd1, 32'h0000_0000, "R9");
    ticks(1);
    // back to system mode
    @(negedge clk);
    user_mode = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_rd(3'd0, 32'h7FFF_FE00, "R11");
    bus_rd(3'd1, 32'h0000_0000, "R11");
    chk_irq(1'b0, "R11");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R12: %0d reads unanswered expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule